// File: doc/BRIEF.md
# Paged Memory Read Sequencer with Page CRC

This block runs the two memory-read commands of a serial slave device that holds a 2624-byte memory. When a command byte is handed to it and the code is one of the two read codes, it collects a two-byte start address from the byte receiver. It then answers every byte request from the master with the next sequential memory byte, taken from a synchronous read port that has one cycle of latency. Addresses that arrive out of range are folded back before reading begins. Every location past the end of memory reads as all ones.

The extended variant splits the stream into 32-byte pages. After the last byte of each page it inserts the bit-inverted CRC-16 of that page. For the first page the CRC also covers the command byte and both address bytes. A bus reset input aborts either command at any byte. Starting either command raises a sticky flag that bars a later scratchpad copy until the scratchpad is rewritten.

Top module: `mem_read_seq`

## Requirements
- R1: A start with command code F0h (plain read) or A5h (extended read) is accepted only while the block is idle. Any other code is ignored: the flag does not change and later requests get no reply.
- R2: The address arrives as two received bytes, low byte first. A 16-bit value above 0A3Fh has its bits 15..12 cleared before reading starts. The result may still point past the end of memory.
- R3: In the data phase, a request accepted in cycle t drives mem_en_o with the current address in cycle t. The byte appears on tx_data_o with tx_valid_o in cycle t+1, and the address then advances by one.
- R4: Every byte requested beyond 0A3Fh reads FFh. The memory port is never enabled for such an address.
- R5: In extended mode, the request after the byte at page offset 31 returns the inverted CRC low byte. The request after that returns the inverted CRC high byte. The next request returns the first byte of the following page.
- R6: The CRC uses polynomial x^16+x^15+x^2+1, starts from zero and takes each byte least significant bit first. The first page's CRC covers the command byte, the two raw address bytes and the page's data. Each later page's CRC covers only its own data bytes.
- R7: In extended mode, pages beyond the end of memory hold FFh data and still end with their inverted CRC.
- R8: In plain mode, no CRC is inserted at page boundaries.
- R9: bus_rst_i aborts any command. From the next cycle tx_valid_o is low, and requests get no reply until a new command is accepted.
- R10: block_flag_o is cleared by rst_ni and set in the cycle after a command is accepted. It survives bus_rst_i and falls only on flag_clr_i. When a command is accepted in the same cycle as flag_clr_i, the set wins.
- R11: Byte requests made while idle or while the address is still being received are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command byte present on cmd_i |
| cmd_i | input | 8 | Command code |
| bus_rst_i | input | 1 | Bus reset seen; aborts the command |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Master requests the next byte |
| tx_valid_o | output | 1 | Reply byte valid (one cycle after request) |
| tx_data_o | output | 8 | Reply byte |
| mem_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | 12 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after enable |
| flag_clr_i | input | 1 | Scratchpad rewritten; clears the block flag |
| block_flag_o | output | 1 | Scratchpad copy blocked |

## Verification
The block flag can receive a set, from an accepted read command, and a clear, from a scratchpad rewrite, in the same cycle. The bench provokes this by raising start_i with a read code and flag_clr_i on the same clock edge while the flag is already set. It first clears the flag alone, so that a plain clear is also seen. The flag is judged high on the next cycle. A second overlap occurs when the CRC accumulates the last data byte of a page in the same cycle as the request for the first CRC byte. Back-to-back request vectors provoke this, and the CRC byte is compared with a value the bench computes itself.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR_LO, ST_ADDR_HI, ST_DATA, ST_CRC_LO, ST_CRC_HI
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_MEM, SRC_ONES, SRC_CRC_LO, SRC_CRC_HI
  } tx_src_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // reflected CRC-16, lsb of the byte first
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [7:0]  din);
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else               c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mrs_addr_fold.sv
module mrs_addr_fold #(
  parameter int unsigned IN_W      = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_BYTES = 2624
) (
  input  logic [IN_W-1:0]   raw_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              past_end_o
);
  localparam logic [IN_W-1:0] LAST_RAW = IN_W'(MEM_BYTES - 1);

  logic [IN_W-1:0] masked;

  always_comb begin
    masked = raw_i;
    if (raw_i > LAST_RAW) masked[IN_W-1:ADDR_W] = '0;
  end

  assign addr_o     = masked[ADDR_W-1:0];
  assign past_end_o = masked > LAST_RAW;
endmodule

// File: rtl/mrs_crc_reg.sv
module mrs_crc_reg
  import mrs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        upd_i,
  input  logic        seed_zero_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (upd_i) crc_q <= crc16_step(seed_zero_i ? 16'h0000 : crc_q, din_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mrs_tx_stage.sv
module mrs_tx_stage
  import mrs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        abort_i,
  input  logic        fire_i,
  input  tx_src_e     src_i,
  input  logic [7:0]  mem_rdata_i,
  input  logic [15:0] crc_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output tx_src_e     src_o
);
  logic    valid_q;
  tx_src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= SRC_MEM;
    end else if (abort_i) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire_i;
      if (fire_i) src_q <= src_i;
    end
  end

  // crc bytes read crc_i live so the last data byte of the page is included
  always_comb begin
    unique case (src_q)
      SRC_MEM:    tx_data_o = mem_rdata_i;
      SRC_ONES:   tx_data_o = 8'hFF;
      SRC_CRC_LO: tx_data_o = ~crc_i[7:0];
      default:    tx_data_o = ~crc_i[15:8];
    endcase
  end

  assign tx_valid_o = valid_q;
  assign src_o      = src_q;
endmodule

// File: rtl/mem_read_seq.sv
module mem_read_seq
  import mrs_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 2624,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned IN_W       = 16,
  parameter int unsigned PAGE_BYTES = 32,
  parameter logic [7:0]  CMD_PLAIN  = 8'hF0,
  parameter logic [7:0]  CMD_EXT    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        cmd_i,
  input  logic              bus_rst_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_req_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              mem_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              flag_clr_i,
  output logic              block_flag_o
);
  localparam int unsigned       PAGE_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MEM_BYTES - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              pe_q, ext_q, restart_q, flag_q;
  logic [7:0]        lo_q;

  logic              cmd_known, start_ok, rx_take, req_take, data_req, page_end;
  logic              data_out_upd, crc_upd, crc_seed_zero;
  logic [7:0]        crc_din;
  logic [15:0]       crc;
  logic [ADDR_W-1:0] fold_addr;
  logic              fold_pe;
  tx_src_e           src_d, src_cur;

  assign cmd_known = (cmd_i == CMD_PLAIN) || (cmd_i == CMD_EXT);
  assign start_ok  = start_i && !bus_rst_i && (state_q == ST_IDLE) && cmd_known;
  assign rx_take   = rx_valid_i && !bus_rst_i &&
                     (state_q == ST_ADDR_LO || state_q == ST_ADDR_HI);
  assign req_take  = tx_req_i && !bus_rst_i &&
                     (state_q == ST_DATA || state_q == ST_CRC_LO || state_q == ST_CRC_HI);
  assign data_req  = req_take && (state_q == ST_DATA);
  assign page_end  = &ptr_q[PAGE_W-1:0];

  mrs_addr_fold #(
    .IN_W      (IN_W),
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES)
  ) u_fold (
    .raw_i      ({rx_data_i, lo_q}),
    .addr_o     (fold_addr),
    .past_end_o (fold_pe)
  );

  always_comb begin
    state_d = state_q;
    if (bus_rst_i) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:    if (start_ok)   state_d = ST_ADDR_LO;
        ST_ADDR_LO: if (rx_valid_i) state_d = ST_ADDR_HI;
        ST_ADDR_HI: if (rx_valid_i) state_d = ST_DATA;
        ST_DATA:    if (tx_req_i && ext_q && page_end) state_d = ST_CRC_LO;
        ST_CRC_LO:  if (tx_req_i)   state_d = ST_CRC_HI;
        ST_CRC_HI:  if (tx_req_i)   state_d = ST_DATA;
        default:                    state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CRC_LO: src_d = SRC_CRC_LO;
      ST_CRC_HI: src_d = SRC_CRC_HI;
      default:   src_d = pe_q ? SRC_ONES : SRC_MEM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      pe_q      <= 1'b0;
      ext_q     <= 1'b0;
      restart_q <= 1'b0;
      lo_q      <= '0;
    end else begin
      state_q <= state_d;
      if (bus_rst_i) begin
        restart_q <= 1'b0;
      end else begin
        if (start_ok) begin
          ext_q     <= (cmd_i == CMD_EXT);
          restart_q <= 1'b0;
        end
        if (rx_take && state_q == ST_ADDR_LO) lo_q <= rx_data_i;
        if (rx_take && state_q == ST_ADDR_HI) begin
          ptr_q <= fold_addr;
          pe_q  <= fold_pe;
        end
        if (data_req) begin
          ptr_q <= ptr_q + ADDR_W'(1);
          if (ptr_q == LAST_A) pe_q <= 1'b1;
        end
        // next page's crc restarts from zero
        if (req_take && state_q == ST_CRC_HI) restart_q <= 1'b1;
        else if (data_out_upd)                restart_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (start_ok)   flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  mrs_tx_stage u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (bus_rst_i),
    .fire_i      (req_take),
    .src_i       (src_d),
    .mem_rdata_i (mem_rdata_i),
    .crc_i       (crc),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .src_o       (src_cur)
  );

  assign data_out_upd  = tx_valid_o && (src_cur == SRC_MEM || src_cur == SRC_ONES);
  assign crc_upd       = start_ok || rx_take || data_out_upd;
  assign crc_seed_zero = start_ok || (data_out_upd && restart_q);
  assign crc_din       = start_ok ? cmd_i : (rx_take ? rx_data_i : tx_data_o);

  mrs_crc_reg u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (crc_upd),
    .seed_zero_i (crc_seed_zero),
    .din_i       (crc_din),
    .crc_o       (crc)
  );

  assign mem_en_o     = data_req && !pe_q;
  assign mem_addr_o   = ptr_q;
  assign block_flag_o = flag_q;
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
  parameter int unsigned MEM_BYTES = 2624,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [7:0]  CMD_PLAIN = 8'hF0,
  parameter logic [7:0]  CMD_EXT   = 8'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [7:0]        cmd_i,
  input logic              bus_rst_i,
  input logic              tx_req_i,
  input logic              tx_valid_o,
  input logic              mem_en_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              flag_clr_i,
  input logic              block_flag_o
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(MEM_BYTES - 1);

  AST_REPLY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(tx_req_i)); // R3

  AST_MEM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_addr_o <= LAST_A)); // R4

  AST_ABORT_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !tx_valid_o); // R9

  AST_FLAG_RISE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(block_flag_o) |-> $past(start_i && (cmd_i == CMD_PLAIN || cmd_i == CMD_EXT))); // R1

  AST_FLAG_FALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(block_flag_o) |-> $past(flag_clr_i)); // R10

  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_flag_o && start_i && !bus_rst_i && flag_clr_i &&
     (cmd_i == CMD_PLAIN || cmd_i == CMD_EXT)) |=> block_flag_o || $past(!block_flag_o)); // R10
endmodule

bind mem_read_seq mrs_checker #(
  .MEM_BYTES (MEM_BYTES),
  .ADDR_W    (ADDR_W),
  .CMD_PLAIN (CMD_PLAIN),
  .CMD_EXT   (CMD_EXT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cmd_i        (cmd_i),
  .bus_rst_i    (bus_rst_i),
  .tx_req_i     (tx_req_i),
  .tx_valid_o   (tx_valid_o),
  .mem_en_o     (mem_en_o),
  .mem_addr_o   (mem_addr_o),
  .flag_clr_i   (flag_clr_i),
  .block_flag_o (block_flag_o)
);

// File: tb/mem_read_seq_tb.sv
module mem_read_seq_tb;
  localparam int unsigned MEM_BYTES = 2624;
  localparam logic [11:0] LAST_A    = 12'(MEM_BYTES - 1);
  localparam int NV = 8;
  // {burst, cmd, raw address, requests}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'hF0, 16'h0010, 16'd20},  // R3 R8 plain across a page edge
    {1'b1, 8'hA5, 16'h0010, 16'd52},  // R5 R6 back-to-back, two crcs
    {1'b0, 8'hF0, 16'h0A3C, 16'd8},   // R4 running off the end
    {1'b1, 8'hA5, 16'h0A30, 16'd52},  // R7 ones page after the end
    {1'b0, 8'hF0, 16'hF123, 16'd6},   // R2 folded to 0123h
    {1'b0, 8'hA5, 16'h1A3F, 16'd37},  // R2 R7 folded to 0A3Fh
    {1'b1, 8'hF0, 16'h0B00, 16'd6},   // R2 R4 unfolded, still past end
    {1'b0, 8'hA5, 16'h0000, 16'd34}   // R6 full first page
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bus_rst = 1'b0, rx_valid = 1'b0, tx_req = 1'b0, flag_clr = 1'b0;
  logic [7:0]  cmd = '0, rx_data = '0, mem_rdata = '0;
  logic        tx_valid, mem_en, block_flag;
  logic [7:0]  tx_data;
  logic [11:0] mem_addr;
  int          checks = 0, errors = 0, bad_mem = 0;

  always #5 clk = ~clk;

  mem_read_seq u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cmd_i (cmd),
    .bus_rst_i (bus_rst), .rx_valid_i (rx_valid), .rx_data_i (rx_data),
    .tx_req_i (tx_req), .tx_valid_o (tx_valid), .tx_data_o (tx_data),
    .mem_en_o (mem_en), .mem_addr_o (mem_addr), .mem_rdata_i (mem_rdata),
    .flag_clr_i (flag_clr), .block_flag_o (block_flag)
  );

  function automatic logic [7:0] mem_val(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  function automatic logic [15:0] crc_b(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_en) mem_rdata <= mem_val(mem_addr);
    if (mem_en && mem_addr > LAST_A) bad_mem <= bad_mem + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [7:0] c, input bit clr);
    @(negedge clk); start = 1'b1; cmd = c; flag_clr = clr;
    @(negedge clk); start = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // one request, output sampled at the following negedge
  task automatic req_one(output logic v, output logic [7:0] d);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; v = tx_valid; d = tx_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic        v;
    logic [7:0]  d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(block_flag == 1'b0, "R10 reset flag", 16'(block_flag), 16'h0);
    chk(tx_valid == 1'b0, "R9 reset tx_valid", 16'(tx_valid), 16'h0);

    // R1 unknown code ignored
    start_cmd(8'h33, 1'b0);
    chk(block_flag == 1'b0, "R1 unknown code flag", 16'(block_flag), 16'h0);
    send_rx(8'h00); send_rx(8'h00);
    req_one(v, d);
    chk(v == 1'b0, "R1 unknown code no reply", 16'(v), 16'h0);
    pulse_bus_rst();

    // R11 request during address phase ignored
    start_cmd(8'hF0, 1'b0);
    req_one(v, d);
    chk(v == 1'b0, "R11 req in address phase", 16'(v), 16'h0);
    send_rx(8'h05); send_rx(8'h00);
    req_one(v, d);
    chk(v && d == mem_val(12'h005), "R11 R3 first byte after ignored req", {7'b0, v, d}, {8'h01, mem_val(12'h005)});

    // R9 abort mid-stream
    req_one(v, d);
    chk(v && d == mem_val(12'h006), "R9 byte before abort", {7'b0, v, d}, {8'h01, mem_val(12'h006)});
    pulse_bus_rst();
    chk(block_flag == 1'b1, "R10 flag survives bus reset", 16'(block_flag), 16'h1);
    req_one(v, d);
    chk(v == 1'b0, "R9 no reply after abort", 16'(v), 16'h0);

    // R10 plain clear, then set and clear together
    pulse_clr();
    chk(block_flag == 1'b0, "R10 clear alone", 16'(block_flag), 16'h0);
    start_cmd(8'hA5, 1'b0);
    pulse_bus_rst();
    start_cmd(8'hF0, 1'b1);
    chk(block_flag == 1'b1, "R10 set wins over clear", 16'(block_flag), 16'h1);
    pulse_bus_rst();

    for (int vi = 0; vi < NV; vi++) begin
      logic        burst, ext, pe, restart;
      logic [7:0]  c8, exp;
      logic [15:0] raw, crc;
      logic [11:0] p;
      int          n, phase;
      string       tag;
      burst = VEC[vi][40]; c8 = VEC[vi][39:32]; raw = VEC[vi][31:16]; n = int'(VEC[vi][15:0]);
      ext = (c8 == 8'hA5);
      pulse_clr();
      start_cmd(c8, 1'b0);
      chk(block_flag == 1'b1, "R10 flag set by command", 16'(block_flag), 16'h1);
      send_rx(raw[7:0]); send_rx(raw[15:8]);
      p  = (raw > 16'(LAST_A)) ? raw[11:0] : raw[11:0];
      pe = ({4'h0, p} > 16'(LAST_A));
      crc = crc_b(crc_b(crc_b(16'h0, c8), raw[7:0]), raw[15:8]);
      phase = 0; restart = 1'b0;
      @(negedge clk); tx_req = 1'b1;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        if (!burst || k == n - 1) tx_req = 1'b0;
        if (phase == 1) begin
          exp = ~crc[7:0]; phase = 2; tag = "R5 R6 crc low";
        end else if (phase == 2) begin
          exp = ~crc[15:8]; phase = 0; restart = 1'b1; tag = "R5 R6 crc high";
        end else begin
          exp = pe ? 8'hFF : mem_val(p);
          tag = pe ? (ext ? "R4 R7 ones data" : "R4 ones data") : (ext ? "R3 data" : "R3 R8 data");
          crc = crc_b(restart ? 16'h0 : crc, exp);
          restart = 1'b0;
          if (ext && p[4:0] == 5'd31) phase = 1;
          if (p == LAST_A) pe = 1'b1;
          p = p + 12'd1;
        end
        chk(tx_valid && tx_data == exp, tag, {7'b0, tx_valid, tx_data}, {8'h01, exp});
        if (!burst && k != n - 1) begin
          @(negedge clk); tx_req = 1'b1;
        end
      end
      pulse_bus_rst();
    end

    chk(bad_mem == 0, "R4 memory port past end", 16'(bad_mem), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule